// File: doc/BRIEF.md
# Floating-point exception flag accumulator

This block sits next to a floating-point datapath. Each time an operation completes, the datapath gives a one-cycle status strobe and a vector of cause bits. The block folds those causes into eight sticky flag bits of the floating-point control/status register. When the flags are non-zero after an update, it raises a floating-point exception request. Many invalid-operation causes collapse into one invalid flag. A few of them also set a flag of their own. A single enable bit from the control register gates both the flag update and the request.

The request is a one-cycle pulse, one clock after the strobe. It comes with the address of the previous instruction, which is the faulting address. Software can overwrite the flag register at any time, for example to clear the flags. A software write in the same cycle as a strobe wins. The arithmetic itself and the jump to the exception vector belong to other blocks.

Top module: `fpe_flag_accum`

## Requirements
- R1: After a synchronous reset, `flags` is 0, `exc_req` is 0 and `exc_addr` is 0.
- R2: While `fpe_en` is 0, a strobe changes no flag bit and raises no `exc_req`.
- R3: An enabled strobe with any invalid-operation cause sets flag bit 0 (invalid). The invalid causes are `cause` bits 0 to 8: 0 signalling NaN, 1 quiet NaN, 2 inf-inf, 3 inf/inf, 4 0/0, 5 inf*0, 6 bad conversion, 7 bad compare, 8 bad square root.
- R4: Cause bit 0 also sets flag bit 1 (signalling NaN). Cause bit 1 also sets flag bit 2 (quiet NaN).
- R5: Cause bit 9 (overflow) sets flag bit 3. Cause bit 10 (underflow) sets flag bit 4.
- R6: Cause bits 2 and 3 (inf-inf, inf/inf) also set flag bit 5 (infinity).
- R7: Cause bit 11 (divide by zero) sets flag bit 6. Cause bit 12 (inexact) sets flag bit 7.
- R8: Flags are sticky. An update only ORs new bits into the register. With no write and no enabled strobe, the register holds its value.
- R9: When `wr_en` is 1, `flags` takes `wr_flags` on the next edge. In that cycle any strobe is dropped: its causes are lost and it raises no request.
- R10: An enabled strobe without a write gives `exc_req` = 1 on the following cycle exactly when the flags after that update are non-zero. This includes flags left over from earlier strobes. `exc_addr` then equals `prev_pc` from the strobe cycle. In all other cycles `exc_req` is 0.
- R11: `exc_addr` keeps its value in every cycle where `exc_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stb | input | 1 | One-cycle status strobe from the datapath |
| cause | input | 13 | Cause bits, valid with `stb` |
| fpe_en | input | 1 | Exception enable bit from the control register |
| wr_en | input | 1 | Software write to the flag field |
| wr_flags | input | 8 | Flag value written by software |
| prev_pc | input | ADDR_W | Address of the previous instruction |
| flags | output | 8 | Sticky flag register |
| exc_req | output | 1 | One-cycle exception request |
| exc_addr | output | ADDR_W | Faulting address for the request |

## Verification
The hardest situation to reach from the ports is a strobe that arrives in the same cycle as a software write. The write must win, and the strobe's causes must leave no trace in either the flags or the request. Directed steps cover this. Random stimulus also raises `wr_en` and `stb` together often.

A second hard case is a request that comes only from older sticky flags, with an empty cause vector. The bench reaches it by first setting a flag, then strobing with zero causes, and later clearing the flags by a write before another empty strobe. Random phases toggle `fpe_en` so that disabled strobes fall between enabled ones.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  // cause vector positions
  localparam int CAUSE_W    = 13;
  localparam int C_SNAN     = 0;
  localparam int C_QNAN     = 1;
  localparam int C_INF_SUB  = 2;
  localparam int C_INF_DIV  = 3;
  localparam int C_ZERO_DIV = 4;
  localparam int C_INF_MUL  = 5;
  localparam int C_CONV     = 6;
  localparam int C_CMP      = 7;
  localparam int C_SQRT     = 8;
  localparam int C_INV_LAST = 8;
  localparam int C_OVF      = 9;
  localparam int C_UNF      = 10;
  localparam int C_DZ       = 11;
  localparam int C_INEXACT  = 12;

  // flag register positions
  localparam int FLAG_W  = 8;
  localparam int F_INV   = 0;
  localparam int F_SNAN  = 1;
  localparam int F_QNAN  = 2;
  localparam int F_OVF   = 3;
  localparam int F_UNF   = 4;
  localparam int F_INF   = 5;
  localparam int F_DZ    = 6;
  localparam int F_INEX  = 7;

  typedef logic [CAUSE_W-1:0] cause_t;
  typedef logic [FLAG_W-1:0]  flag_t;
endpackage

// File: rtl/fpe_cause_map.sv
module fpe_cause_map
  import fpe_pkg::*;
(
  input  cause_t cause,
  output flag_t  set_mask
);
  localparam int INV_N = C_INV_LAST + 1;

  logic [INV_N-1:0] inv_bits;

  genvar gi;
  generate
    for (gi = 0; gi < INV_N; gi++) begin : g_inv
      assign inv_bits[gi] = cause[gi];
    end
  endgenerate

  always_comb begin
    set_mask          = '0;
    set_mask[F_INV]   = |inv_bits;
    set_mask[F_SNAN]  = cause[C_SNAN];
    set_mask[F_QNAN]  = cause[C_QNAN];
    set_mask[F_OVF]   = cause[C_OVF];
    set_mask[F_UNF]   = cause[C_UNF];
    set_mask[F_INF]   = cause[C_INF_SUB] | cause[C_INF_DIV];
    set_mask[F_DZ]    = cause[C_DZ];
    set_mask[F_INEX]  = cause[C_INEXACT];
  end
endmodule

// File: rtl/fpe_flag_reg.sv
module fpe_flag_reg
  import fpe_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  upd,
  input  flag_t set_mask,
  input  logic  wr_en,
  input  flag_t wr_flags,
  output flag_t flags,
  output flag_t next_flags,
  output logic  upd_taken
);
  // write beats strobe in the same cycle
  assign upd_taken  = upd & ~wr_en;
  assign next_flags = flags | set_mask;

  always_ff @(posedge clk) begin
    if (rst)
      flags <= '0;
    else if (wr_en)
      flags <= wr_flags;
    else if (upd_taken)
      flags <= next_flags;
  end
endmodule

// File: rtl/fpe_raise.sv
module fpe_raise
  import fpe_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_taken,
  input  flag_t             next_flags,
  input  logic [ADDR_W-1:0] prev_pc,
  output logic              exc_req,
  output logic [ADDR_W-1:0] exc_addr
);
  logic fire;
  assign fire = upd_taken & (|next_flags);

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_req  <= 1'b0;
      exc_addr <= '0;
    end else begin
      exc_req <= fire;
      if (fire)
        exc_addr <= prev_pc;
    end
  end
endmodule

// File: rtl/fpe_flag_accum.sv
module fpe_flag_accum
  import fpe_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                stb,
  input  logic [CAUSE_W-1:0]  cause,
  input  logic                fpe_en,
  input  logic                wr_en,
  input  logic [FLAG_W-1:0]   wr_flags,
  input  logic [ADDR_W-1:0]   prev_pc,
  output logic [FLAG_W-1:0]   flags,
  output logic                exc_req,
  output logic [ADDR_W-1:0]   exc_addr
);
  flag_t set_mask;
  flag_t next_flags;
  logic  upd_taken;
  logic  upd;

  assign upd = stb & fpe_en;

  fpe_cause_map u_map (
    .cause    (cause),
    .set_mask (set_mask)
  );

  fpe_flag_reg u_flags (
    .clk        (clk),
    .rst        (rst),
    .upd        (upd),
    .set_mask   (set_mask),
    .wr_en      (wr_en),
    .wr_flags   (wr_flags),
    .flags      (flags),
    .next_flags (next_flags),
    .upd_taken  (upd_taken)
  );

  fpe_raise #(.ADDR_W(ADDR_W)) u_raise (
    .clk        (clk),
    .rst        (rst),
    .upd_taken  (upd_taken),
    .next_flags (next_flags),
    .prev_pc    (prev_pc),
    .exc_req    (exc_req),
    .exc_addr   (exc_addr)
  );
endmodule

// File: rtl/fpe_flag_accum_chk.sv
module fpe_flag_accum_chk
  import fpe_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input logic               clk,
  input logic               rst,
  input logic               stb,
  input logic [CAUSE_W-1:0] cause,
  input logic               fpe_en,
  input logic               wr_en,
  input logic [FLAG_W-1:0]  wr_flags,
  input logic [ADDR_W-1:0]  prev_pc,
  input logic [FLAG_W-1:0]  flags,
  input logic               exc_req,
  input logic [ADDR_W-1:0]  exc_addr
);
  p_quiet_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    (!fpe_en && !wr_en) |=> ($stable(flags) && !exc_req));

  p_invalid_r3: assert property (@(posedge clk) disable iff (rst)
    (stb && fpe_en && !wr_en && (|cause[C_INV_LAST:0])) |=> flags[F_INV]);

  p_infinity_r6: assert property (@(posedge clk) disable iff (rst)
    (stb && fpe_en && !wr_en && (cause[C_INF_SUB] || cause[C_INF_DIV])) |=> flags[F_INF]);

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((flags & $past(flags)) == $past(flags)));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (flags == $past(wr_flags) && !exc_req));

  p_req_source_r10: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> $past(stb && fpe_en && !wr_en));

  p_req_addr_r10: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (exc_addr == $past(prev_pc)));

  p_req_flags_r10: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (flags != '0));

  p_addr_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !exc_req |-> $stable(exc_addr));
endmodule

bind fpe_flag_accum fpe_flag_accum_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_fpe_flag_accum.sv
module sim_fpe_flag_accum;
  localparam int AW = 32;
  localparam int CW = 13;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          stb;
  logic [CW-1:0] cause;
  logic          fpe_en;
  logic          wr_en;
  logic [FW-1:0] wr_flags;
  logic [AW-1:0] prev_pc;
  logic [FW-1:0] flags;
  logic          exc_req;
  logic [AW-1:0] exc_addr;

  int n_checks = 0;
  int n_errors = 0;

  logic [FW-1:0] m_flags;
  logic          m_req;
  logic [AW-1:0] m_addr;

  always #10 clk = ~clk;

  fpe_flag_accum #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .stb(stb), .cause(cause), .fpe_en(fpe_en),
    .wr_en(wr_en), .wr_flags(wr_flags), .prev_pc(prev_pc),
    .flags(flags), .exc_req(exc_req), .exc_addr(exc_addr)
  );

  // expected flag bits straight from the requirement text
  function automatic logic [FW-1:0] want_mask(input logic [CW-1:0] c);
    logic [FW-1:0] m;
    m = '0;
    for (int i = 0; i <= 8; i++) if (c[i]) m[0] = 1'b1;  // R3
    if (c[0]) m[1] = 1'b1;                                // R4
    if (c[1]) m[2] = 1'b1;                                // R4
    if (c[9]) m[3] = 1'b1;                                // R5
    if (c[10]) m[4] = 1'b1;                               // R5
    if (c[2] || c[3]) m[5] = 1'b1;                        // R6
    if (c[11]) m[6] = 1'b1;                               // R7
    if (c[12]) m[7] = 1'b1;                               // R7
    return m;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model, check after the edge
  task automatic step(input string tag, input logic s, input logic [CW-1:0] c,
                      input logic en, input logic w, input logic [FW-1:0] wd,
                      input logic [AW-1:0] pc);
    logic [FW-1:0] nf;
    @(negedge clk);
    stb = s; cause = c; fpe_en = en; wr_en = w; wr_flags = wd; prev_pc = pc;
    if (w) begin
      m_flags = wd; m_req = 1'b0;
    end else if (s && en) begin
      nf = m_flags | want_mask(c);
      m_req = (nf != '0);
      if (m_req) m_addr = pc;
      m_flags = nf;
    end else begin
      m_req = 1'b0;
    end
    @(posedge clk);
    #5;
    chk({tag, " flags"}, AW'(flags), AW'(m_flags));
    chk({tag, " req"}, AW'(exc_req), AW'(m_req));
    chk({tag, " addr"}, exc_addr, m_addr);
  endtask

  initial begin
    #(20 * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; stb = 0; cause = '0; fpe_en = 0; wr_en = 0; wr_flags = '0; prev_pc = '0;
    m_flags = '0; m_req = 0; m_addr = '0;
    repeat (3) @(posedge clk);
    #5;
    chk("R1 flags", AW'(flags), '0);
    chk("R1 req", AW'(exc_req), '0);
    chk("R1 addr", exc_addr, '0);
    @(negedge clk);
    rst = 1'b0;

    step("R2 disabled", 1, 13'h1fff, 0, 0, 8'h00, 32'h100);
    step("R2 idle", 0, 13'h0000, 1, 0, 8'h00, 32'h104);
    // each cause alone, then clear by write
    for (int b = 0; b < CW; b++) begin
      step("R3 R4 R5 R6 R7 single cause", 1, CW'(1) << b, 1, 0, 8'h00, 32'h2000 + 32'(b * 4));
      step("R11 hold", 0, '0, 1, 0, 8'h00, 32'hdead);
      step("R9 clear", 0, '0, 1, 1, 8'h00, 32'h0);
    end
    // R10: request from sticky flags with empty causes
    step("R10 set", 1, 13'h0200, 1, 0, 8'h00, 32'h3000);
    step("R10 sticky-only", 1, 13'h0000, 1, 0, 8'h00, 32'h3004);
    step("R8 accumulate", 1, 13'h1000, 1, 0, 8'h00, 32'h3008);
    step("R9 write wins", 1, 13'h1fff, 1, 1, 8'h00, 32'h300c);
    step("R10 empty no req", 1, 13'h0000, 1, 0, 8'h00, 32'h3010);
    step("R9 write value", 0, '0, 1, 1, 8'ha5, 32'h0);
    step("R2 disabled keep", 1, 13'h0fff, 0, 0, 8'h00, 32'h3014);

    for (int i = 0; i < 600; i++) begin
      step("R8 R10 random", ($urandom % 3) != 0, CW'($urandom),
           ($urandom % 4) != 0, ($urandom % 6) == 0, FW'($urandom % 3 == 0 ? 0 : $urandom),
           $urandom);
    end
    summary();
  end
endmodule